// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the opcode and function fields of a fetched instruction into the select and enable signals that steer a single-cycle datapath. It picks the destination register, the second ALU operand (register or immediate), the memory read and write strobes, register write, the write-back source and the next-PC source. It also produces a 3-bit ALU operation code in two steps. First, a 2-bit instruction class is derived from the opcode. Then the class, together with a function selector, yields the final ALU code.

The recognised forms are loads, stores, register-register arithmetic, branch-on-equal, jump, jump-and-link, jump-to-register and four immediate ALU forms. Every output is registered. The control for an instruction presented in one cycle appears after the next rising clock edge. An opcode or function code that is not recognised yields no register write and no memory write, and keeps the PC sequential.

Top module: `ctl_decode`

## Requirements
- R1: While `rst` is high at a rising edge, every output becomes 0 on that edge, whatever the instruction inputs carry.
- R2: Outputs are registered: the control for `opcode`/`funct` sampled at one rising edge appears right after that edge. The field encodings are as follows. `reg_dst` is 0 for rt, 1 for rd and 2 for register 31. `wb_sel` is 0 for ALU, 1 for memory and 2 for link PC. `pc_sel` is 0 for sequential, 1 for branch, 2 for jump and 3 for register. `alu_class` is 0 for memory, 1 for branch, 2 for function decode and 3 for jump. `alu_op` is AND=000, OR=001, add=010, subtract=110 and set-less-than=111.
- R3: With opcode 0, the funct values 100000, 100010, 100100, 100101 and 101010 give add, subtract, AND, OR and set-less-than respectively. All five also give reg_dst=1, alu_src=0, reg_wr=1, wb_sel=0, pc_sel=0 and alu_class=2.
- R4: Opcode 35 (load) gives alu_class=0, alu_op=add, alu_src=1, mem_rd=1, reg_wr=1, wb_sel=1 and reg_dst=0.
- R5: Opcode 43 (store) gives alu_class=0, alu_op=add, alu_src=1, mem_wr=1, reg_wr=0 and mem_rd=0.
- R6: Opcode 4 (branch-on-equal) gives alu_class=1, alu_op=subtract, alu_src=0, pc_sel=1 and no writes.
- R7: Opcode 2 (jump) and opcode 3 (jump-and-link) both give pc_sel=2, alu_class=3 and alu_op=add. Jump writes nothing. Jump-and-link gives reg_wr=1, reg_dst=2 and wb_sel=2.
- R8: Opcode 0 with funct 001000 (jump-to-register) gives pc_sel=3, reg_wr=0, alu_class=2 and alu_op=add.
- R9: The immediate ALU opcodes 8, 10, 12 and 13 give add, set-less-than, AND and OR respectively. All four also give alu_src=1, reg_dst=0, reg_wr=1, wb_sel=0 and alu_class=2.
- R10: Any other opcode gives all outputs 0 except alu_op=add. Any other funct under opcode 0 gives reg_wr=0, no memory access, pc_sel=0, alu_class=2 and alu_op=add.
- R11: `mem_rd` and `mem_wr` are never both high, and `reg_wr` is never high together with `mem_wr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Instruction function field |
| reg_dst | output | 2 | Destination register select |
| alu_src | output | 1 | Second ALU operand: 0 register, 1 immediate |
| mem_rd | output | 1 | Data memory read enable |
| mem_wr | output | 1 | Data memory write enable |
| reg_wr | output | 1 | Register file write enable |
| wb_sel | output | 2 | Write-back source select |
| pc_sel | output | 2 | Next-PC source select |
| alu_class | output | 2 | Instruction class code |
| alu_op | output | 3 | Final ALU operation code |

## Verification
The hardest situation to reach is a function field that matters only under one opcode. Jump-to-register and the unknown function codes must disable writes under opcode 0, while the same funct bits under other opcodes must have no effect. The stimulus therefore sweeps all 64 opcodes twice, once with a valid arithmetic funct and once with the jump-to-register funct, after the directed cases. It also drives a load while reset is held, to show that reset dominates the decode.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OPW  = 6;
  localparam int FNW  = 6;
  localparam int ALUW = 3;

  localparam logic [OPW-1:0] OP_RTYPE = 6'd0;
  localparam logic [OPW-1:0] OP_J     = 6'd2;
  localparam logic [OPW-1:0] OP_JAL   = 6'd3;
  localparam logic [OPW-1:0] OP_BEQ   = 6'd4;
  localparam logic [OPW-1:0] OP_ADDI  = 6'd8;
  localparam logic [OPW-1:0] OP_SLTI  = 6'd10;
  localparam logic [OPW-1:0] OP_ANDI  = 6'd12;
  localparam logic [OPW-1:0] OP_ORI   = 6'd13;
  localparam logic [OPW-1:0] OP_LW    = 6'd35;
  localparam logic [OPW-1:0] OP_SW    = 6'd43;

  localparam logic [FNW-1:0] FN_JR  = 6'b001000;
  localparam logic [FNW-1:0] FN_ADD = 6'b100000;
  localparam logic [FNW-1:0] FN_SUB = 6'b100010;
  localparam logic [FNW-1:0] FN_AND = 6'b100100;
  localparam logic [FNW-1:0] FN_OR  = 6'b100101;
  localparam logic [FNW-1:0] FN_SLT = 6'b101010;

  localparam logic [ALUW-1:0] ALU_AND = 3'b000;
  localparam logic [ALUW-1:0] ALU_OR  = 3'b001;
  localparam logic [ALUW-1:0] ALU_ADD = 3'b010;
  localparam logic [ALUW-1:0] ALU_SUB = 3'b110;
  localparam logic [ALUW-1:0] ALU_SLT = 3'b111;

  typedef enum logic [1:0] {DST_RT = 2'd0, DST_RD = 2'd1, DST_LINK = 2'd2} dst_e;
  typedef enum logic [1:0] {WB_ALU = 2'd0, WB_MEM = 2'd1, WB_PC = 2'd2} wb_e;
  typedef enum logic [1:0] {PC_SEQ = 2'd0, PC_BR = 2'd1, PC_JMP = 2'd2, PC_REG = 2'd3} pc_e;
  typedef enum logic [1:0] {CL_MEM = 2'd0, CL_BR = 2'd1, CL_FN = 2'd2, CL_JMP = 2'd3} cls_e;

  typedef struct packed {
    dst_e  dst;
    logic  src_imm;
    logic  mrd;
    logic  mwr;
    logic  rwr;
    wb_e   wb;
    pc_e   pc;
    cls_e  cls;
  } ctl_t;
endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
  import ctl_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [FNW-1:0] fn_i,
  output ctl_t           ctl_o,
  output logic [FNW-1:0] fsel_o
);
  always_comb begin
    ctl_o  = '0;
    fsel_o = fn_i;
    case (op_i)
      OP_RTYPE: begin
        ctl_o.cls = CL_FN;
        case (fn_i)
          FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT: begin
            ctl_o.dst = DST_RD;
            ctl_o.rwr = 1'b1;
          end
          FN_JR:   ctl_o.pc = PC_REG;
          default: ;
        endcase
      end
      OP_LW: begin
        ctl_o.src_imm = 1'b1;
        ctl_o.mrd     = 1'b1;
        ctl_o.rwr     = 1'b1;
        ctl_o.wb      = WB_MEM;
      end
      OP_SW: begin
        ctl_o.src_imm = 1'b1;
        ctl_o.mwr     = 1'b1;
      end
      OP_BEQ: begin
        ctl_o.cls = CL_BR;
        ctl_o.pc  = PC_BR;
      end
      OP_J: begin
        ctl_o.cls = CL_JMP;
        ctl_o.pc  = PC_JMP;
      end
      OP_JAL: begin
        ctl_o.cls = CL_JMP;
        ctl_o.pc  = PC_JMP;
        ctl_o.rwr = 1'b1;
        ctl_o.dst = DST_LINK;
        ctl_o.wb  = WB_PC;
      end
      OP_ADDI, OP_SLTI, OP_ANDI, OP_ORI: begin
        ctl_o.cls     = CL_FN;
        ctl_o.src_imm = 1'b1;
        ctl_o.rwr     = 1'b1;
        case (op_i)
          OP_SLTI: fsel_o = FN_SLT;
          OP_ANDI: fsel_o = FN_AND;
          OP_ORI:  fsel_o = FN_OR;
          default: fsel_o = FN_ADD;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
  import ctl_pkg::*;
(
  input  cls_e            cls_i,
  input  logic [FNW-1:0]  fsel_i,
  output logic [ALUW-1:0] op_o
);
  always_comb begin
    case (cls_i)
      CL_BR: op_o = ALU_SUB;
      CL_FN: begin
        case (fsel_i)
          FN_SUB:  op_o = ALU_SUB;
          FN_AND:  op_o = ALU_AND;
          FN_OR:   op_o = ALU_OR;
          FN_SLT:  op_o = ALU_SLT;
          default: op_o = ALU_ADD;
        endcase
      end
      default: op_o = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
  import ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  output logic [1:0]  reg_dst,
  output logic        alu_src,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        reg_wr,
  output logic [1:0]  wb_sel,
  output logic [1:0]  pc_sel,
  output logic [1:0]  alu_class,
  output logic [2:0]  alu_op
);
  ctl_t            ctl_n, ctl_q;
  logic [FNW-1:0]  fsel;
  logic [ALUW-1:0] op_n, op_q;

  ctl_main_dec u_main (.op_i(opcode), .fn_i(funct), .ctl_o(ctl_n), .fsel_o(fsel));
  ctl_alu_dec  u_alu  (.cls_i(ctl_n.cls), .fsel_i(fsel), .op_o(op_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      op_q  <= '0;
    end else begin
      ctl_q <= ctl_n;
      op_q  <= op_n;
    end
  end

  assign reg_dst   = ctl_q.dst;
  assign alu_src   = ctl_q.src_imm;
  assign mem_rd    = ctl_q.mrd;
  assign mem_wr    = ctl_q.mwr;
  assign reg_wr    = ctl_q.rwr;
  assign wb_sel    = ctl_q.wb;
  assign pc_sel    = ctl_q.pc;
  assign alu_class = ctl_q.cls;
  assign alu_op    = op_q;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (reg_wr == 1'b0 && mem_wr == 1'b0 && pc_sel == 2'd0 && alu_op == 3'd0));

  assert_mem_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr) && !(reg_wr && mem_wr));

  assert_branch_sub_R6: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_BEQ) |=> (alu_class == 2'd1 && alu_op == ALU_SUB && !reg_wr && !mem_wr));

  assert_link_R7: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_JAL) |=> (reg_dst == 2'd2 && wb_sel == 2'd2 && reg_wr && pc_sel == 2'd2));

  assert_jr_nowrite_R8: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_RTYPE && funct == FN_JR) |=> (pc_sel == 2'd3 && !reg_wr));

  assert_load_add_R4: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_LW) |=> (alu_op == ALU_ADD && mem_rd && wb_sel == 2'd1));

  assert_unknown_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (opcode == 6'd63) |=> (!reg_wr && !mem_wr && !mem_rd && pc_sel == 2'd0));
endmodule

// File: tb/tb_ctl_decode.sv
module tb_ctl_decode;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [5:0] funct  = '0;
  logic [1:0] reg_dst, wb_sel, pc_sel, alu_class;
  logic alu_src, mem_rd, mem_wr, reg_wr;
  logic [2:0] alu_op;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [14:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  ctl_decode dut (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct),
    .reg_dst(reg_dst), .alu_src(alu_src), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .reg_wr(reg_wr), .wb_sel(wb_sel), .pc_sel(pc_sel),
    .alu_class(alu_class), .alu_op(alu_op)
  );

  function automatic logic [14:0] pack(logic [1:0] d, logic s, logic r, logic w,
                                       logic rw, logic [1:0] wb, logic [1:0] pc,
                                       logic [1:0] c, logic [2:0] o);
    return {d, s, r, w, rw, wb, pc, c, o};
  endfunction

  function automatic logic [14:0] model(logic [5:0] op, logic [5:0] fn);
    case (op)
      6'd0: case (fn)
        6'b100000: return pack(2'd1, 0, 0, 0, 1, 2'd0, 2'd0, 2'd2, 3'b010);
        6'b100010: return pack(2'd1, 0, 0, 0, 1, 2'd0, 2'd0, 2'd2, 3'b110);
        6'b100100: return pack(2'd1, 0, 0, 0, 1, 2'd0, 2'd0, 2'd2, 3'b000);
        6'b100101: return pack(2'd1, 0, 0, 0, 1, 2'd0, 2'd0, 2'd2, 3'b001);
        6'b101010: return pack(2'd1, 0, 0, 0, 1, 2'd0, 2'd0, 2'd2, 3'b111);
        6'b001000: return pack(2'd0, 0, 0, 0, 0, 2'd0, 2'd3, 2'd2, 3'b010);
        default:   return pack(2'd0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd2, 3'b010);
      endcase
      6'd35: return pack(2'd0, 1, 1, 0, 1, 2'd1, 2'd0, 2'd0, 3'b010);
      6'd43: return pack(2'd0, 1, 0, 1, 0, 2'd0, 2'd0, 2'd0, 3'b010);
      6'd4:  return pack(2'd0, 0, 0, 0, 0, 2'd0, 2'd1, 2'd1, 3'b110);
      6'd2:  return pack(2'd0, 0, 0, 0, 0, 2'd0, 2'd2, 2'd3, 3'b010);
      6'd3:  return pack(2'd2, 0, 0, 0, 1, 2'd2, 2'd2, 2'd3, 3'b010);
      6'd8:  return pack(2'd0, 1, 0, 0, 1, 2'd0, 2'd0, 2'd2, 3'b010);
      6'd10: return pack(2'd0, 1, 0, 0, 1, 2'd0, 2'd0, 2'd2, 3'b111);
      6'd12: return pack(2'd0, 1, 0, 0, 1, 2'd0, 2'd0, 2'd2, 3'b000);
      6'd13: return pack(2'd0, 1, 0, 0, 1, 2'd0, 2'd0, 2'd2, 3'b001);
      default: return pack(2'd0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0, 3'b010);
    endcase
  endfunction

  function automatic logic [14:0] outs();
    return {reg_dst, alu_src, mem_rd, mem_wr, reg_wr, wb_sel, pc_sel, alu_class, alu_op};
  endfunction

  task automatic drive(input logic [5:0] op, input logic [5:0] fn, input string tag);
    item_t it;
    @(negedge clk);
    opcode = op;
    funct  = fn;
    it.exp = model(op, fn);
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: result of an item driven at a falling edge is visible just after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (outs() !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, outs(), it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    opcode = 6'd35;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (outs() !== 15'd0) begin
      errors++;
      $display("FAIL R1: got %h expected %h", outs(), 15'd0);
    end
    rst = 1'b0;

    drive(6'd0, 6'b100000, "R3 add");
    drive(6'd0, 6'b100010, "R3 sub");
    drive(6'd0, 6'b100100, "R3 and");
    drive(6'd0, 6'b100101, "R3 or");
    drive(6'd0, 6'b101010, "R3 slt");
    drive(6'd35, 6'b101010, "R4 load");
    drive(6'd43, 6'b100100, "R5 store");
    drive(6'd4, 6'b100101, "R6 beq");
    drive(6'd2, 6'b100000, "R7 jump");
    drive(6'd3, 6'b100010, "R7 jal");
    drive(6'd0, 6'b001000, "R8 jr");
    drive(6'd8, 6'b100010, "R9 addi");
    drive(6'd10, 6'b100000, "R9 slti");
    drive(6'd12, 6'b100101, "R9 andi");
    drive(6'd13, 6'b100100, "R9 ori");
    drive(6'd63, 6'b100000, "R10 unknown opcode");
    drive(6'd0, 6'b111111, "R10 unknown funct");
    drive(6'd0, 6'b000000, "R10 zero funct");
    // back-to-back changes every cycle exercise R2 latency
    drive(6'd43, 6'd0, "R2 store then load");
    drive(6'd35, 6'd0, "R2 load after store");
    for (int i = 0; i < 64; i++) drive(i[5:0], 6'b100010, "R10 sweep sub funct");
    for (int i = 0; i < 64; i++) drive(i[5:0], 6'b001000, "R11 sweep jr funct");

    // R1: reset during a load clears outputs
    @(negedge clk);
    rst = 1'b1;
    opcode = 6'd35;
    @(posedge clk);
    #1;
    @(negedge clk);
    checks++;
    if (outs() !== 15'd0) begin
      errors++;
      $display("FAIL R1 reset dominates: got %h expected %h", outs(), 15'd0);
    end
    rst = 1'b0;
    drive(6'd3, 6'd0, "R7 jal after reset");
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule